// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing for one successive-approximation analog-to-digital conversion, clocked by the CPU clock. A start pulse opens a sample window, then a 40-period conversion phase, then a fixed 2-cycle completion overhead, after which a one-cycle done pulse is issued. A step strobe is given once per converter period during the conversion phase, so an external successive-approximation register can advance its bit trial from it. A busy flag covers the whole conversion.

Two 2-bit codes program the timing. One picks the divisor that derives the converter period from the CPU clock. The other picks the sample length as a count of converter periods. Both codes are captured when a start is accepted, so a conversion that is already running always finishes with the timing it started with. At a 25 MHz CPU clock with both codes at zero, the converter period is 160 ns, the sample window is 1280 ns and the whole conversion takes 194 CPU cycles (7.76 µs, about 7.8 µs).

Top module: `adc_seq_top`

## Requirements
- R1: After a synchronous active-high reset, busy, sample_en, sar_step and done are all low.
- R2: The divisor code clk_sel selects the converter period in CPU cycles: 2'b00 gives 4, 2'b01 gives 2, 2'b10 gives 16, 2'b11 gives 8.
- R3: The sample code smp_sel selects the sample length in converter periods: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32, 2'b11 gives 64. sample_en is high from the cycle after the accepted start for exactly that length times the divisor, and falls exactly when the sample phase ends.
- R4: During the conversion phase sar_step pulses exactly 40 times, one cycle each, on the last CPU cycle of each converter period, and never while sample_en is high.
- R5: busy is high from the cycle after an accepted start for exactly (sample length + 40) × divisor + 2 cycles; with both codes 2'b00 this is 194 cycles.
- R6: done is a single-cycle pulse in the first cycle in which busy is low again after a conversion.
- R7: A start while busy is ignored, and changes to clk_sel or smp_sel during a conversion do not alter that conversion's timing.
- R8: A reset asserted during a conversion returns the block to idle on the next cycle, with busy, sample_en and done low.
- R9: A start in the cycle done is high is accepted, and busy and sample_en are high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only when idle |
| clk_sel | input | 2 | Converter-period divisor code |
| smp_sel | input | 2 | Sample-length code |
| busy | output | 1 | Conversion in progress |
| sample_en | output | 1 | Sample window open |
| sar_step | output | 1 | Per-period strobe for the approximation register |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The done pulse of one conversion and the acceptance of the next start can fall in the same cycle. The bench raises start on exactly the cycle where done is observed high and expects busy and sample_en on the following cycle, while its behavioural model, which treats the done cycle as idle, is compared against every output on every clock. A start and new codes given mid-conversion are judged by the unchanged busy length, sample count and step count of the running conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_W = 5;   // holds divisors up to 16
    localparam int SMP_W = 7;   // holds sample lengths up to 64

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_TAIL    = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SMP_W-1:0] smp;
    } seq_cfg_t;

    // Non-monotonic code to divisor mapping
    function automatic logic [DIV_W-1:0] div_decode(input logic [1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            2'b00:   r = DIV_W'(4);
            2'b01:   r = DIV_W'(2);
            2'b10:   r = DIV_W'(16);
            default: r = DIV_W'(8);
        endcase
        return r;
    endfunction

    // Sample length doubles with each code step from 8
    function automatic logic [SMP_W-1:0] smp_decode(input logic [1:0] code);
        return SMP_W'(8) << code;
    endfunction

endpackage

// File: rtl/adc_cfg_latch.sv
module adc_cfg_latch
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] clk_sel,
    input  logic [1:0] smp_sel,
    output seq_cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.div <= div_decode(2'b00);
            cfg.smp <= smp_decode(2'b00);
        end else if (load) begin
            cfg.div <= div_decode(clk_sel);
            cfg.smp <= smp_decode(smp_sel);
        end
    end

endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_PERIODS = 40,
    parameter int TAIL_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       tick,
    input  seq_cfg_t   cfg,
    output seq_state_t state,
    output logic       accept,
    output logic       done
);

    localparam int MAX_A = (64 > CONV_PERIODS) ? 64 : CONV_PERIODS;
    localparam int MAX_PH = (MAX_A > TAIL_CYCLES) ? MAX_A : TAIL_CYCLES;
    localparam int PH_W = $clog2(MAX_PH + 1);

    logic [PH_W-1:0] ph;

    assign accept = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ph    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    ph <= '0;
                    if (start) state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        if (ph == PH_W'(cfg.smp) - PH_W'(1)) begin
                            state <= ST_CONVERT;
                            ph    <= '0;
                        end else begin
                            ph <= ph + PH_W'(1);
                        end
                    end
                end
                ST_CONVERT: begin
                    if (tick) begin
                        if (ph == PH_W'(CONV_PERIODS - 1)) begin
                            state <= ST_TAIL;
                            ph    <= '0;
                        end else begin
                            ph <= ph + PH_W'(1);
                        end
                    end
                end
                default: begin
                    if (ph == PH_W'(TAIL_CYCLES - 1)) begin
                        state <= ST_IDLE;
                        ph    <= '0;
                        done  <= 1'b1;
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int CONV_PERIODS = 40,
    parameter int TAIL_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] clk_sel,
    input  logic [1:0] smp_sel,
    output logic       busy,
    output logic       sample_en,
    output logic       sar_step,
    output logic       done
);

    seq_cfg_t   cfg;
    seq_state_t state;
    logic       accept;
    logic       tick;
    logic       run;

    adc_cfg_latch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .clk_sel (clk_sel),
        .smp_sel (smp_sel),
        .cfg     (cfg)
    );

    assign run = (state == ST_SAMPLE) || (state == ST_CONVERT);

    adc_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg.div),
        .tick (tick)
    );

    adc_phase_fsm #(
        .CONV_PERIODS (CONV_PERIODS),
        .TAIL_CYCLES  (TAIL_CYCLES)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (tick),
        .cfg    (cfg),
        .state  (state),
        .accept (accept),
        .done   (done)
    );

    assign busy      = (state != ST_IDLE);
    assign sample_en = (state == ST_SAMPLE);
    assign sar_step  = (state == ST_CONVERT) && tick;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic sample_en,
    input logic sar_step,
    input logic done
);

    // R3
    smp_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy);

    // R4
    step_in_convert_chk: assert property (@(posedge clk) disable iff (rst)
        sar_step |-> (busy && !sample_en));

    // R6
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> done);

    // R4
    outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_en, sar_step, done}));

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(rst)) |-> $past(start));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !sample_en && !done));

endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .sample_en (sample_en),
    .sar_step  (sar_step),
    .done      (done)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic [1:0] smp_sel = 2'b00;
    logic       busy, sample_en, sar_step, done;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_top dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .clk_sel   (clk_sel),
        .smp_sel   (smp_sel),
        .busy      (busy),
        .sample_en (sample_en),
        .sar_step  (sar_step),
        .done      (done)
    );

    function automatic int div_of(input logic [1:0] c);
        case (c)
            2'b00:   return 4;
            2'b01:   return 2;
            2'b10:   return 16;
            default: return 8;
        endcase
    endfunction

    function automatic int smp_of(input logic [1:0] c);
        case (c)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: k counts cycles since the accepted start
    int k = 0;
    int m_div = 4;
    int m_slen = 32;
    int m_tot = 194;

    always @(posedge clk) begin
        if (rst) begin
            k = 0;
        end else if ((k == 0 || k == m_tot + 1) && start) begin
            m_div  = div_of(clk_sel);
            m_slen = smp_of(smp_sel) * m_div;
            m_tot  = m_slen + 40 * m_div + 2;
            k = 1;
        end else if (k != 0 && k <= m_tot) begin
            k = k + 1;
        end else begin
            k = 0;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            bit e_busy, e_smp, e_step, e_done;
            e_busy = (k >= 1) && (k <= m_tot);
            e_smp  = (k >= 1) && (k <= m_slen);
            e_step = (k > m_slen) && (k <= m_slen + 40 * m_div) && (((k - m_slen) % m_div) == 0);
            e_done = (k == m_tot + 1);
            chk(busy == e_busy, "R5 busy model", int'(busy), int'(e_busy));
            chk(sample_en == e_smp, "R3 sample_en model", int'(sample_en), int'(e_smp));
            chk(sar_step == e_step, "R4 sar_step model", int'(sar_step), int'(e_step));
            chk(done == e_done, "R6 done model", int'(done), int'(e_done));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    // Runs one conversion; returns on the negedge where busy has fallen
    task automatic run_conv(input logic [1:0] cs, input logic [1:0] ss, input bit disturb);
        int cnt, steps, smp, exp_t;
        @(negedge clk);
        clk_sel = cs;
        smp_sel = ss;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0; steps = 0; smp = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            steps += int'(sar_step);
            smp   += int'(sample_en);
            if (disturb && cnt == 60) begin
                start   = 1'b1;
                clk_sel = ~cs;
                smp_sel = ~ss;
            end
            if (disturb && cnt == 61) start = 1'b0;
            @(negedge clk);
        end
        exp_t = (smp_of(ss) + 40) * div_of(cs) + 2;
        chk(cnt == exp_t, disturb ? "R7 busy length" : "R2 busy length", cnt, exp_t);
        chk(smp == smp_of(ss) * div_of(cs), disturb ? "R7 sample count" : "R3 sample count",
            smp, smp_of(ss) * div_of(cs));
        chk(steps == 40, "R4 step count", steps, 40);
        chk(done == 1'b1, "R6 done at busy fall", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !sample_en && !sar_step && !done, "R1 reset state",
            int'({busy, sample_en, sar_step, done}), 0);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);

        // R5: 25 MHz example, both codes zero gives 194 CPU cycles
        run_conv(2'b00, 2'b00, 1'b0);

        // R2 R3 R4: all code combinations
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                run_conv(2'(c), 2'(s), 1'b0);
            end
        end

        // R7: start and new codes mid-conversion are ignored
        run_conv(2'b00, 2'b00, 1'b1);
        run_conv(2'b01, 2'b01, 1'b1);

        // R9: start on the done cycle is accepted
        run_conv(2'b01, 2'b00, 1'b0);
        clk_sel = 2'b11;
        smp_sel = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && sample_en, "R9 back-to-back start", int'({busy, sample_en}), 3);
        while (busy) @(negedge clk);
        chk(done == 1'b1, "R9 done after chained run", int'(done), 1);

        // R8: reset mid-conversion
        @(negedge clk);
        clk_sel = 2'b10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R8 busy before reset", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !sample_en && !done, "R8 idle after reset", int'({busy, sample_en, done}), 0);
        run_conv(2'b11, 2'b00, 1'b0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule